// File: doc/BRIEF.md
# Serial EEPROM Block Transfer Sequencer

This block moves one 256-byte block between a local byte-wide buffer and a serial EEPROM over a four-wire SPI link. A single command chooses the direction and names a 16-bit block index. The block index becomes the two high address bytes and the low address byte is always zero, so every transfer starts on a 256-byte boundary.

A read is one chip-select frame: the read opcode, three address bytes, then 256 bytes that are clocked in and written to the local buffer in address order. A write is a chain of frames. The sequencer reads the status register first. If any protection bit is set, it writes the status back with those bits cleared. It then sends write-enable, then the write opcode with the address and 256 bytes taken from the buffer. Last, it re-reads the status until the device reports that its internal write cycle has finished. Only then does it signal completion.

The SPI link runs in mode 0 with the most significant bit first. The serial clock is derived from the system clock by a parameterized divider. Chip select stays high for at least two serial clock periods between frames.

Top module: `eeprom_blk_seq`

## Requirements
- R1: `busy` rises in the cycle after a command is accepted (`cmd_valid` high while idle). It stays high up to and including the single cycle in which `done` pulses, and it is low afterwards. A `cmd_valid` seen while `busy` is high starts no frame and yields no further `done`.
- R2: The link uses SPI mode 0. `spi_sck` idles low and `spi_mosi` holds steady while `spi_sck` is high. Bits go MSB first, and each half period of `spi_sck` lasts `SCK_DIV` system clocks.
- R3: Between two frames, `spi_cs_n` stays high for at least 4*`SCK_DIV` system clocks, which is two serial clock periods.
- R4: A read (`cmd_write`=0) is one frame of 260 bytes: 0x03, block[15:8], block[7:0], 0x00, then 256 received bytes. Received byte k is written to buffer address k through `buf_wr_en`/`buf_wdata`.
- R5: A write (`cmd_write`=1) begins with a status-read frame of exactly two bytes: opcode 0x05 sent, then one status byte received.
- R6: If the status byte has bit 2, bit 3 or bit 7 set, a status-write frame of two bytes follows: 0x01, then the status ANDed with 0x73. If none of those bits is set, this frame is left out.
- R7: The next frame is a write-enable frame containing the single byte 0x06.
- R8: The next frame is the write frame of 260 bytes: 0x02, block[15:8], block[7:0], 0x00, then buffer bytes 0 to 255 in order. The buffer is read combinationally: `buf_rdata` must reflect `buf_addr` in the same cycle.
- R9: After the write frame, the block sends two-byte status-read frames (0x05) until one returns bit 0 clear. `done` pulses only after that frame closes, and no other frame follows.
- R10: During reset and just after it, `spi_cs_n` is 1, `spi_sck` is 0, and `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken only while idle |
| cmd_write | input | 1 | 1 = write the block to the device, 0 = read it |
| cmd_block | input | 16 | Block index (address bits 23:8) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| buf_addr | output | 8 | Local buffer byte address |
| buf_rd_en | output | 1 | Buffer byte being loaded for transmission |
| buf_rdata | input | 8 | Buffer read data, combinational from buf_addr |
| buf_wr_en | output | 1 | Write strobe for a received byte |
| buf_wdata | output | 8 | Received byte |
| spi_cs_n | output | 1 | Device chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
Two paths are hardest to reach from the ports. One is the conditional status-write frame. The other is a busy-poll loop that runs more than once. Both depend only on what the device answers, never on the command. The bench therefore contains a device model whose status register and write-cycle length are preset before each write. Directed writes start with all protect bits set, with none set, and with a long write cycle. Randomized writes draw the status byte and the poll count. A second command is pulsed during a write to show that it is ignored.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  // protect bits: bit7, bit3, bit2 ; busy bit: bit0
  localparam logic [7:0] ST_PROT_MASK = 8'h8C;
  localparam int         ST_WIP_BIT   = 0;

  localparam int HDR_BYTES = 4;

  typedef enum logic [2:0] {
    FR_STAT  = 3'd0,
    FR_UNPROT = 3'd1,
    FR_WEN   = 3'd2,
    FR_PROG  = 3'd3,
    FR_POLL  = 3'd4,
    FR_FETCH = 3'd5
  } frame_e;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_LOAD  = 3'd1,
    SQ_SHIFT = 3'd2,
    SQ_GAP   = 3'd3,
    SQ_FIN   = 3'd4
  } seq_state_e;

endpackage

// File: rtl/eeprom_spi_shifter.sv
module eeprom_spi_shifter #(
  parameter int SCK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       mosi_o,
  output logic [7:0] rx_o,
  output logic       done_o,
  output logic       active_o
);

  localparam int CW = (SCK_DIV > 1) ? $clog2(SCK_DIV) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(SCK_DIV - 1);

  logic          act_q, act_d;
  logic          sck_q, sck_d;
  logic [2:0]    bit_q, bit_d;
  logic [CW-1:0] div_q, div_d;
  logic [7:0]    tx_q, tx_d;
  logic [7:0]    rx_q, rx_d;
  logic          done_q, done_d;

  always_comb begin
    act_d  = act_q;
    sck_d  = sck_q;
    bit_d  = bit_q;
    div_d  = div_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    done_d = 1'b0;
    if (!act_q) begin
      if (start_i) begin
        act_d = 1'b1;
        tx_d  = tx_i;
        div_d = '0;
        bit_d = '0;
        sck_d = 1'b0;
      end
    end else if (div_q == DIV_LAST) begin
      div_d = '0;
      if (!sck_q) begin
        sck_d = 1'b1;
        rx_d  = {rx_q[6:0], miso_i};
      end else begin
        sck_d = 1'b0;
        tx_d  = {tx_q[6:0], 1'b0};
        if (bit_q == 3'd7) begin
          act_d  = 1'b0;
          done_d = 1'b1;
        end else begin
          bit_d = bit_q + 3'd1;
        end
      end
    end else begin
      div_d = div_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sck_q  <= 1'b0;
      bit_q  <= '0;
      div_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      sck_q  <= sck_d;
      bit_q  <= bit_d;
      div_q  <= div_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      done_q <= done_d;
    end
  end

  assign sck_o    = sck_q;
  assign mosi_o   = tx_q[7];
  assign rx_o     = rx_q;
  assign done_o   = done_q;
  assign active_o = act_q;

  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_o && $past(sck_o)) |-> $stable(mosi_o)) else $error("mosi moved while sck high"); // R2

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !active_o) else $error("byte started while shifting"); // R2

endmodule

// File: rtl/eeprom_seq_ctrl.sv
module eeprom_seq_ctrl
  import eeprom_seq_pkg::*;
#(
  parameter int SCK_DIV   = 2,
  parameter int BLK_BYTES = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid_i,
  input  logic        cmd_write_i,
  input  logic [15:0] cmd_block_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [$clog2(BLK_BYTES)-1:0] buf_addr_o,
  output logic        buf_rd_en_o,
  input  logic [7:0]  buf_rdata_i,
  output logic        buf_wr_en_o,
  output logic [7:0]  buf_wdata_o,
  output logic        cs_n_o,
  output logic        eng_start_o,
  output logic [7:0]  eng_tx_o,
  input  logic [7:0]  eng_rx_i,
  input  logic        eng_done_i
);

  localparam int AW      = $clog2(BLK_BYTES);
  localparam int DATA_LAST = HDR_BYTES + BLK_BYTES - 1;
  localparam int IW      = $clog2(DATA_LAST + 1);
  localparam int GAP_CYC = 4 * SCK_DIV;
  localparam int GW      = $clog2(GAP_CYC + 1);

  seq_state_e     st_q, st_d;
  frame_e         fr_q, fr_d;
  logic [IW-1:0]  idx_q, idx_d;
  logic [15:0]    blk_q, blk_d;
  logic [7:0]     stat_q, stat_d;
  logic           cs_n_q, cs_n_d;
  logic [GW-1:0]  gap_q, gap_d;
  logic           fin_q, fin_d;

  logic [IW-1:0]  last_idx;
  logic [IW-1:0]  data_off;
  logic           in_data;
  logic           is_status_rd;

  always_comb begin
    unique case (fr_q)
      FR_STAT, FR_POLL, FR_UNPROT: last_idx = IW'(1);
      FR_WEN:                      last_idx = '0;
      default:                     last_idx = IW'(DATA_LAST);
    endcase
  end

  assign data_off     = idx_q - IW'(HDR_BYTES);
  assign in_data      = (idx_q >= IW'(HDR_BYTES));
  assign is_status_rd = (fr_q == FR_STAT) || (fr_q == FR_POLL);

  // byte to transmit for the current frame position
  always_comb begin
    eng_tx_o = 8'h00;
    unique case (fr_q)
      FR_STAT, FR_POLL: eng_tx_o = (idx_q == '0) ? OP_RDSR : 8'h00;
      FR_UNPROT:        eng_tx_o = (idx_q == '0) ? OP_WRSR : (stat_q & ~ST_PROT_MASK);
      FR_WEN:           eng_tx_o = OP_WREN;
      FR_PROG, FR_FETCH: begin
        if (in_data)               eng_tx_o = (fr_q == FR_PROG) ? buf_rdata_i : 8'h00;
        else if (idx_q == IW'(0))  eng_tx_o = (fr_q == FR_PROG) ? OP_WRITE : OP_READ;
        else if (idx_q == IW'(1))  eng_tx_o = blk_q[15:8];
        else if (idx_q == IW'(2))  eng_tx_o = blk_q[7:0];
        else                       eng_tx_o = 8'h00;
      end
      default: eng_tx_o = 8'h00;
    endcase
  end

  always_comb begin
    st_d        = st_q;
    fr_d        = fr_q;
    idx_d       = idx_q;
    blk_d       = blk_q;
    stat_d      = stat_q;
    cs_n_d      = cs_n_q;
    gap_d       = gap_q;
    fin_d       = fin_q;
    eng_start_o = 1'b0;
    buf_rd_en_o = 1'b0;
    buf_wr_en_o = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (cmd_valid_i) begin
          blk_d = cmd_block_i;
          fr_d  = cmd_write_i ? FR_STAT : FR_FETCH;
          idx_d = '0;
          fin_d = 1'b0;
          st_d  = SQ_LOAD;
        end
      end
      SQ_LOAD: begin
        cs_n_d      = 1'b0;
        eng_start_o = 1'b1;
        buf_rd_en_o = (fr_q == FR_PROG) && in_data;
        st_d        = SQ_SHIFT;
      end
      SQ_SHIFT: begin
        if (eng_done_i) begin
          if (is_status_rd && (idx_q == IW'(1))) stat_d = eng_rx_i;
          if ((fr_q == FR_FETCH) && in_data)     buf_wr_en_o = 1'b1;
          if (idx_q == last_idx) begin
            cs_n_d = 1'b1;
            gap_d  = '0;
            idx_d  = '0;
            st_d   = SQ_GAP;
            unique case (fr_q)
              FR_STAT:   fr_d = ((eng_rx_i & ST_PROT_MASK) != 8'h00) ? FR_UNPROT : FR_WEN;
              FR_UNPROT: fr_d = FR_WEN;
              FR_WEN:    fr_d = FR_PROG;
              FR_PROG:   fr_d = FR_POLL;
              FR_POLL:   fin_d = !eng_rx_i[ST_WIP_BIT];
              default:   fin_d = 1'b1;
            endcase
          end else begin
            idx_d = idx_q + IW'(1);
            st_d  = SQ_LOAD;
          end
        end
      end
      SQ_GAP: begin
        gap_d = gap_q + GW'(1);
        if (gap_q == GW'(GAP_CYC - 1)) st_d = fin_q ? SQ_FIN : SQ_LOAD;
      end
      SQ_FIN: begin
        fin_d = 1'b0;
        st_d  = SQ_IDLE;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      fr_q   <= FR_STAT;
      idx_q  <= '0;
      blk_q  <= '0;
      stat_q <= '0;
      cs_n_q <= 1'b1;
      gap_q  <= '0;
      fin_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      fr_q   <= fr_d;
      idx_q  <= idx_d;
      blk_q  <= blk_d;
      stat_q <= stat_d;
      cs_n_q <= cs_n_d;
      gap_q  <= gap_d;
      fin_q  <= fin_d;
    end
  end

  assign busy_o      = (st_q != SQ_IDLE);
  assign done_o      = (st_q == SQ_FIN);
  assign cs_n_o      = cs_n_q;
  assign buf_addr_o  = data_off[AW-1:0];
  assign buf_wdata_o = eng_rx_i;

  AST_BUSY_IGNORES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o && cmd_valid_i) |=> $stable(blk_q)) else $error("command taken while busy"); // R1

  AST_BUF_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_rd_en_o && buf_wr_en_o)) else $error("buffer read and write together"); // R8

  AST_WR_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_en_o |-> !cs_n_o) else $error("buffer write outside a frame"); // R4

endmodule

// File: rtl/eeprom_blk_seq.sv
module eeprom_blk_seq #(
  parameter int SCK_DIV   = 2,
  parameter int BLK_BYTES = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic        cmd_write,
  input  logic [15:0] cmd_block,
  output logic        busy,
  output logic        done,
  output logic [$clog2(BLK_BYTES)-1:0] buf_addr,
  output logic        buf_rd_en,
  input  logic [7:0]  buf_rdata,
  output logic        buf_wr_en,
  output logic [7:0]  buf_wdata,
  output logic        spi_cs_n,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso
);

  localparam int GAP_CYC = 4 * SCK_DIV;
  localparam int HW      = $clog2(GAP_CYC + 2);

  logic       eng_start;
  logic [7:0] eng_tx;
  logic [7:0] eng_rx;
  logic       eng_done;
  logic       eng_active;

  eeprom_seq_ctrl #(
    .SCK_DIV  (SCK_DIV),
    .BLK_BYTES(BLK_BYTES)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid_i(cmd_valid),
    .cmd_write_i(cmd_write),
    .cmd_block_i(cmd_block),
    .busy_o     (busy),
    .done_o     (done),
    .buf_addr_o (buf_addr),
    .buf_rd_en_o(buf_rd_en),
    .buf_rdata_i(buf_rdata),
    .buf_wr_en_o(buf_wr_en),
    .buf_wdata_o(buf_wdata),
    .cs_n_o     (spi_cs_n),
    .eng_start_o(eng_start),
    .eng_tx_o   (eng_tx),
    .eng_rx_i   (eng_rx),
    .eng_done_i (eng_done)
  );

  eeprom_spi_shifter #(
    .SCK_DIV(SCK_DIV)
  ) shift_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (eng_start),
    .tx_i    (eng_tx),
    .miso_i  (spi_miso),
    .sck_o   (spi_sck),
    .mosi_o  (spi_mosi),
    .rx_o    (eng_rx),
    .done_o  (eng_done),
    .active_o(eng_active)
  );

  // cycles chip select has been high, saturating; starts saturated
  logic [HW-1:0] cs_hi_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cs_hi_q <= HW'(GAP_CYC + 1);
    else if (!spi_cs_n)         cs_hi_q <= '0;
    else if (cs_hi_q != HW'(GAP_CYC + 1)) cs_hi_q <= cs_hi_q + HW'(1);
  end

  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (cs_hi_q >= HW'(GAP_CYC))) else $error("chip select gap too short"); // R3

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck) else $error("sck active with chip select high"); // R2

  AST_DONE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (spi_cs_n && busy && !eng_active)) else $error("done inside a frame"); // R9

endmodule

// File: tb/eeprom_blk_seq_tb_top.sv
`timescale 1ns/1ps
module eeprom_blk_seq_tb_top;

  localparam int DIV  = 2;
  localparam int GAP  = 4 * DIV;
  localparam int MAXF = 16;
  localparam int FLEN = 260;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_write = 1'b0;
  logic [15:0] cmd_block = '0;
  logic        busy, done;
  logic [7:0]  buf_addr;
  logic        buf_rd_en;
  logic [7:0]  buf_rdata;
  logic        buf_wr_en;
  logic [7:0]  buf_wdata;
  logic        spi_cs_n, spi_sck, spi_mosi;
  logic        spi_miso = 1'b0;

  always #2 clk = ~clk;

  eeprom_blk_seq #(.SCK_DIV(DIV), .BLK_BYTES(256)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_block(cmd_block), .busy(busy), .done(done), .buf_addr(buf_addr),
    .buf_rd_en(buf_rd_en), .buf_rdata(buf_rdata), .buf_wr_en(buf_wr_en),
    .buf_wdata(buf_wdata), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int vec = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [7:0] txbuf [256];
  logic [7:0] rxbuf [256];
  assign buf_rdata = txbuf[buf_addr];

  // device model state
  logic [7:0] dev_st = 8'h00;
  int         wip_plan = 0;
  int         wip_left = 0;
  logic [7:0] fr_data [MAXF][FLEN];
  int         fr_len  [MAXF];
  int         nframe = 0;
  int         nbits = 0;
  logic [7:0] cur = 8'h00;
  bit         prev_cs = 1'b1;
  bit         prev_sck = 1'b0;
  int         hi_run = 1000;
  int         min_gap = 1000;
  int         done_cnt = 0;

  function automatic logic [7:0] pat(input logic [15:0] b, input int i);
    return 8'(b[7:0] * 8'd7 + b[15:8] + 8'(i) * 8'd13 + 8'h5A);
  endfunction

  function automatic logic [7:0] dev_out(input int k);
    logic [7:0] op;
    if (k == 0 || nframe >= MAXF) return 8'h00;
    op = fr_data[nframe][0];
    if (op == 8'h05 && k == 1) return {dev_st[7:1], (wip_left > 0)};
    if (op == 8'h03 && k >= 4) return pat({fr_data[nframe][1], fr_data[nframe][2]}, k - 4);
    return 8'h00;
  endfunction

  always @(negedge clk) begin
    if (done) done_cnt++;
    if (buf_wr_en) rxbuf[buf_addr] = buf_wdata;
    if (spi_cs_n) begin
      if (!prev_cs) begin
        if (nframe < MAXF) begin
          fr_len[nframe] = nbits / 8;
          if (fr_data[nframe][0] == 8'h01 && fr_len[nframe] >= 2) dev_st = fr_data[nframe][1] & 8'hFE;
          if (fr_data[nframe][0] == 8'h02) wip_left = wip_plan;
          else if (fr_data[nframe][0] == 8'h05 && wip_left > 0) wip_left--;
        end
        nframe++;
        nbits = 0;
        hi_run = 0;
      end
      hi_run++;
    end else begin
      if (prev_cs && hi_run < min_gap) min_gap = hi_run;
      if (spi_sck && !prev_sck) begin
        cur = {cur[6:0], spi_mosi};
        nbits++;
        if (nbits % 8 == 0 && nframe < MAXF && nbits / 8 <= FLEN) fr_data[nframe][nbits/8 - 1] = cur;
      end
    end
    begin
      logic [7:0] ob;
      ob = dev_out(nbits / 8);
      spi_miso = ob[7 - (nbits % 8)];
    end
    prev_cs  = spi_cs_n;
    prev_sck = spi_sck;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic check_frame(input int f, input string req, input logic [7:0] op, input int len);
    chk(fr_len[f] == len, req, "frame length", fr_len[f], len);
    chk(fr_data[f][0] == op, req, "frame opcode", fr_data[f][0], op);
  endtask

  task automatic issue(input bit wr, input logic [15:0] blk);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_block = blk;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1, "R1", "busy after accept", busy, 1);
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    chk(busy == 1'b1, "R1", "busy during done", busy, 1);
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1", "idle after done", {busy, done}, 0);
  endtask

  task automatic do_read(input logic [15:0] blk);
    int errs;
    nframe = 0; done_cnt = 0;
    for (int i = 0; i < 256; i++) rxbuf[i] = 8'hxx;
    issue(1'b0, blk);
    wait_done();
    chk(nframe == 1, "R4", "read frame count", nframe, 1);
    check_frame(0, "R4", 8'h03, 260);
    chk({fr_data[0][1], fr_data[0][2], fr_data[0][3]} == {blk, 8'h00}, "R4", "read address",
        {fr_data[0][1], fr_data[0][2], fr_data[0][3]}, {blk, 8'h00});
    errs = 0;
    for (int i = 0; i < 256; i++) if (rxbuf[i] !== pat(blk, i)) errs++;
    chk(errs == 0, "R4", "read data mismatches", errs, 0);
  endtask

  task automatic do_write(input logic [15:0] blk, input logic [7:0] st0, input int polls, input bit poke);
    int f, errs, exp_frames;
    bit prot;
    dev_st = st0 & 8'hFE; wip_plan = polls; wip_left = 0;
    prot = (st0 & 8'h8C) != 8'h00;
    for (int i = 0; i < 256; i++) txbuf[i] = 8'($urandom);
    nframe = 0; done_cnt = 0;
    issue(1'b1, blk);
    if (poke) begin
      repeat (40) @(negedge clk);
      cmd_valid = 1'b1; cmd_write = 1'b0; cmd_block = ~blk;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    wait_done();
    repeat (3 * GAP + 40) @(negedge clk);
    exp_frames = (prot ? 4 : 3) + polls + 1;
    chk(nframe == exp_frames, "R9", "write frame count", nframe, exp_frames);
    chk(done_cnt == 1, "R1", "done pulses", done_cnt, 1);
    if (nframe != exp_frames) return;
    check_frame(0, "R5", 8'h05, 2);
    f = 1;
    if (prot) begin
      check_frame(1, "R6", 8'h01, 2);
      chk(fr_data[1][1] == ((st0 & 8'hFE) & 8'h73), "R6", "status write data", fr_data[1][1], (st0 & 8'hFE) & 8'h73);
      f = 2;
    end
    check_frame(f, "R7", 8'h06, 1);
    check_frame(f + 1, "R8", 8'h02, 260);
    chk({fr_data[f+1][1], fr_data[f+1][2], fr_data[f+1][3]} == {blk, 8'h00}, "R8", "write address",
        {fr_data[f+1][1], fr_data[f+1][2], fr_data[f+1][3]}, {blk, 8'h00});
    errs = 0;
    for (int i = 0; i < 256; i++) if (fr_data[f+1][i+4] !== txbuf[i]) errs++;
    chk(errs == 0, "R8", "write data mismatches", errs, 0);
    for (int p = 0; p <= polls; p++) check_frame(f + 2 + p, "R9", 8'h05, 2);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R10", "pins in reset", {spi_cs_n, spi_sck}, 2'b10);
    chk(busy == 1'b0 && done == 1'b0, "R10", "status in reset", {busy, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(spi_cs_n == 1'b1 && busy == 1'b0, "R10", "idle after reset", {spi_cs_n, busy}, 2'b10);

    do_write(16'h1234, 8'h8C, 0, 1'b1);   // all protect bits, busy-time command poke
    do_write(16'h0001, 8'h40, 0, 1'b0);   // no protect bits: status write skipped
    do_write(16'hFFFF, 8'h04, 3, 1'b0);   // long write cycle
    do_read(16'hFFFF);
    do_read(16'h0000);
    for (int n = 0; n < 4; n++) begin
      if (n % 2 == 0) do_write(16'($urandom), 8'($urandom), int'($urandom_range(0, 2)), 1'b0);
      else            do_read(16'($urandom));
    end
    chk(min_gap >= GAP, "R3", "min chip-select gap", min_gap, GAP);
    chk(spi_sck == 1'b0, "R2", "sck idle level", spi_sck, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      vec++; bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

endmodule